// File: doc/BRIEF.md
# Condition code pass evaluator

This block decides whether a conditionally executed instruction is allowed to take effect. It takes the four arithmetic status flags and the current instruction word, finds the 4-bit condition field for the active instruction width, evaluates it against the flags, and reports two things. The first is whether the instruction passes. The second is whether the instruction was actually subject to a condition. It also presents the sequential next-instruction address, which is the address a fetch unit uses when the condition fails.

A mode input selects one of two instruction widths. In the 32-bit width, every instruction carries its condition in its top four bits. In the 16-bit width, only conditional branches are tested, and all other 16-bit opcodes pass without looking at the flags. One request is accepted per clock when the valid input is high. The result is registered and appears one cycle later. While no request is presented, the registered result holds its value.

Top module: `cond_gate`

## Requirements
- R1: While rst_n is low, and after reset until the first request, res_valid_o, pass_o and is_cond_o are 0 and seq_pc_o is 0.
- R2: In 32-bit mode (half_mode_i = 0) the condition is insn_i[31:28]. With flags_i = {N,Z,C,V} (bit 3 = N, bit 2 = Z, bit 1 = C, bit 0 = V), codes 0x0 to 0x7 pass on Z, !Z, C, !C, N, !N, V and !V respectively.
- R3: Code 0x8 passes when C = 1 and Z = 0. Code 0x9 passes when C = 0 or Z = 1.
- R4: Code 0xA passes when N == V. Code 0xB passes when N != V. Code 0xC passes when Z = 0 and N == V. Code 0xD passes when Z = 1 or N != V.
- R5: Codes 0xE and 0xF always pass, and is_cond_o is 0 for them. Codes 0x0 to 0xD give is_cond_o = 1 whenever the field is tested.
- R6: In 16-bit mode (half_mode_i = 1), an opcode with insn_i[15:12] = 0xD is tested with the condition taken from insn_i[11:8], under the same code table as R2 to R5.
- R7: In 16-bit mode, an opcode with insn_i[15:12] != 0xD gives pass_o = 1 and is_cond_o = 0. In 16-bit mode insn_i[31:16] never affects the result.
- R8: seq_pc_o equals pc_i + 4 in 32-bit mode and pc_i + 2 in 16-bit mode, with the sum wrapping at PC_W bits.
- R9: A request with valid_i = 1 at a rising edge produces res_valid_o = 1 and its results after that edge. A cycle with valid_i = 0 gives res_valid_o = 0 at the next edge and leaves pass_o, is_cond_o and seq_pc_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | A request is present this cycle |
| half_mode_i | input | 1 | 1 selects 16-bit instruction handling, 0 selects 32-bit |
| flags_i | input | 4 | Status flags {N,Z,C,V} |
| insn_i | input | INSN_W (32) | Current instruction word; in 16-bit mode only bits 15:0 are used |
| pc_i | input | PC_W (32) | Address of the current instruction |
| res_valid_o | output | 1 | The registered result belongs to a request from the previous cycle |
| pass_o | output | 1 | The instruction is allowed to execute |
| is_cond_o | output | 1 | The instruction was subject to a real condition test |
| seq_pc_o | output | PC_W (32) | Sequential next-instruction address (current address plus instruction size) |

## Verification
The assertions relate each registered result to the request sampled on the previous edge. For that reason they assume that rst_n is released synchronously. They also assume that valid_i, half_mode_i, flags_i, insn_i and pc_i are free of X whenever valid_i is high.

The bench drives inputs only on falling edges, so every sampled value is settled. It sweeps all 16 codes against all 16 flag combinations in both widths. The instruction and address bits outside the condition field are filled with arbitrary values, so results never depend on those bits. Idle cycles are driven with changed inputs, to show that a request that is not valid leaves the outputs untouched.

// File: rtl/cond_pkg.sv
package cond_pkg;

    localparam int COND_W = 4;

    // position of each flag inside the 4-bit flag vector
    localparam int FLAG_N = 3;
    localparam int FLAG_Z = 2;
    localparam int FLAG_C = 1;
    localparam int FLAG_V = 0;

    // 16-bit conditional branch: selector nibble and field position
    localparam logic [3:0] HALF_BRANCH_SEL = 4'hD;
    localparam int HALF_SEL_LSB  = 12;
    localparam int HALF_COND_LSB = 8;

    // instruction sizes in bytes
    localparam int FULL_STEP = 4;
    localparam int HALF_STEP = 2;

    // first code that is unconditional
    localparam logic [COND_W-1:0] COND_ALWAYS_MIN = 4'hE;

    typedef struct packed {
        logic         valid;
        logic         pass;
        logic         is_cond;
        logic [63:0]  seq_pc;   // upper bits unused when PC_W < 64
    } unused_probe_t;

endpackage

// File: rtl/cond_field_pick.sv
module cond_field_pick
    import cond_pkg::*;
#(
    parameter int INSN_W = 32
) (
    input  logic              half_mode_i,
    input  logic [INSN_W-1:0] insn_i,
    output logic [COND_W-1:0] code_o,
    output logic              tested_o
);
    localparam int FULL_COND_LSB = INSN_W - COND_W;

    logic [COND_W-1:0] full_code;
    logic [COND_W-1:0] half_code;
    logic [3:0]        half_sel;
    logic              unused_bits;

    assign full_code = insn_i[FULL_COND_LSB +: COND_W];
    assign half_code = insn_i[HALF_COND_LSB +: COND_W];
    assign half_sel  = insn_i[HALF_SEL_LSB +: 4];

    // bits outside both fields play no part in the decision
    assign unused_bits = ^{insn_i[FULL_COND_LSB-1:HALF_SEL_LSB+4],
                           insn_i[HALF_COND_LSB-1:0]};

    always_comb begin
        if (half_mode_i) begin
            code_o   = half_code;
            tested_o = (half_sel == HALF_BRANCH_SEL);
        end else begin
            code_o   = full_code;
            tested_o = 1'b1;
        end
    end

endmodule

// File: rtl/cond_eval.sv
module cond_eval
    import cond_pkg::*;
(
    input  logic [COND_W-1:0] code_i,
    input  logic [3:0]        flags_i,
    output logic              pass_o
);
    logic n_f, z_f, c_f, v_f;
    logic base;

    assign n_f = flags_i[FLAG_N];
    assign z_f = flags_i[FLAG_Z];
    assign c_f = flags_i[FLAG_C];
    assign v_f = flags_i[FLAG_V];

    // codes come in pairs: the odd member is the complement of the even one
    always_comb begin
        unique case (code_i[3:1])
            3'd0: base = z_f;
            3'd1: base = c_f;
            3'd2: base = n_f;
            3'd3: base = v_f;
            3'd4: base = c_f & ~z_f;
            3'd5: base = ~(n_f ^ v_f);
            3'd6: base = ~z_f & ~(n_f ^ v_f);
            default: base = 1'b1;
        endcase
    end

    assign pass_o = (code_i[3:1] == 3'd7) ? 1'b1 : (base ^ code_i[0]);

endmodule

// File: rtl/cond_gate.sv
module cond_gate
    import cond_pkg::*;
#(
    parameter int INSN_W = 32,
    parameter int PC_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic              half_mode_i,
    input  logic [3:0]        flags_i,
    input  logic [INSN_W-1:0] insn_i,
    input  logic [PC_W-1:0]   pc_i,
    output logic              res_valid_o,
    output logic              pass_o,
    output logic              is_cond_o,
    output logic [PC_W-1:0]   seq_pc_o
);
    localparam logic [PC_W-1:0] FULL_INC = PC_W'(FULL_STEP);
    localparam logic [PC_W-1:0] HALF_INC = PC_W'(HALF_STEP);

    typedef struct packed {
        logic            valid;
        logic            pass;
        logic            is_cond;
        logic [PC_W-1:0] seq_pc;
    } res_t;

    res_t state_d, state_q;

    logic [COND_W-1:0] code;
    logic              tested;
    logic              eval_pass;

    cond_field_pick #(.INSN_W(INSN_W)) u_pick (
        .half_mode_i (half_mode_i),
        .insn_i      (insn_i),
        .code_o      (code),
        .tested_o    (tested)
    );

    cond_eval u_eval (
        .code_i  (code),
        .flags_i (flags_i),
        .pass_o  (eval_pass)
    );

    always_comb begin
        state_d       = state_q;
        state_d.valid = valid_i;
        if (valid_i) begin
            state_d.pass    = tested ? eval_pass : 1'b1;
            state_d.is_cond = tested && (code < COND_ALWAYS_MIN);
            state_d.seq_pc  = pc_i + (half_mode_i ? HALF_INC : FULL_INC);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign res_valid_o = state_q.valid;
    assign pass_o      = state_q.pass;
    assign is_cond_o   = state_q.is_cond;
    assign seq_pc_o    = state_q.seq_pc;

endmodule

module cond_gate_chk #(
    parameter int INSN_W = 32,
    parameter int PC_W   = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              valid_i,
    input logic              half_mode_i,
    input logic [3:0]        flags_i,
    input logic [INSN_W-1:0] insn_i,
    input logic [PC_W-1:0]   pc_i,
    input logic              res_valid_o,
    input logic              pass_o,
    input logic              is_cond_o,
    input logic [PC_W-1:0]   seq_pc_o
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> res_valid_o);                                             // R9
    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> !res_valid_o);                                           // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> ($stable(pass_o) && $stable(is_cond_o) && $stable(seq_pc_o))); // R9
    AST_ALWAYS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !half_mode_i && insn_i[INSN_W-1 -: 3] == 3'b111)
        |=> (pass_o && !is_cond_o));                                          // R5
    AST_HALF_UNCOND: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && half_mode_i && insn_i[15:12] != 4'hD)
        |=> (pass_o && !is_cond_o));                                          // R7
    AST_FULL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !half_mode_i) |=> (seq_pc_o == $past(pc_i) + PC_W'(4)));  // R8
    AST_HALF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && half_mode_i) |=> (seq_pc_o == $past(pc_i) + PC_W'(2)));   // R8
    AST_EQ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !half_mode_i && insn_i[INSN_W-1 -: 4] == 4'h0)
        |=> (pass_o == $past(flags_i[2])));                                   // R2
    AST_GE_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !half_mode_i && insn_i[INSN_W-1 -: 4] == 4'hA)
        |=> (pass_o == ($past(flags_i[3]) == $past(flags_i[0]))));            // R4
    AST_HI_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !half_mode_i && insn_i[INSN_W-1 -: 4] == 4'h8)
        |=> (pass_o == ($past(flags_i[1]) && !$past(flags_i[2]))));           // R3
    AST_HALF_BRANCH_COND: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && half_mode_i && insn_i[15:12] == 4'hD && insn_i[11:9] != 3'b111)
        |=> is_cond_o);                                                       // R6
endmodule

bind cond_gate cond_gate_chk #(.INSN_W(INSN_W), .PC_W(PC_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .valid_i     (valid_i),
    .half_mode_i (half_mode_i),
    .flags_i     (flags_i),
    .insn_i      (insn_i),
    .pc_i        (pc_i),
    .res_valid_o (res_valid_o),
    .pass_o      (pass_o),
    .is_cond_o   (is_cond_o),
    .seq_pc_o    (seq_pc_o)
);

// File: tb/cond_gate_tb.sv
module cond_gate_tb;
    localparam int INSN_W = 32;
    localparam int PC_W   = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              valid_i = 1'b0;
    logic              half_mode_i = 1'b0;
    logic [3:0]        flags_i = '0;
    logic [INSN_W-1:0] insn_i = '0;
    logic [PC_W-1:0]   pc_i = '0;
    logic              res_valid_o;
    logic              pass_o;
    logic              is_cond_o;
    logic [PC_W-1:0]   seq_pc_o;

    always #10 clk = ~clk;   // 50 MHz

    cond_gate #(.INSN_W(INSN_W), .PC_W(PC_W)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .valid_i     (valid_i),
        .half_mode_i (half_mode_i),
        .flags_i     (flags_i),
        .insn_i      (insn_i),
        .pc_i        (pc_i),
        .res_valid_o (res_valid_o),
        .pass_o      (pass_o),
        .is_cond_o   (is_cond_o),
        .seq_pc_o    (seq_pc_o)
    );

    typedef struct {
        logic            pass;
        logic            is_cond;
        logic [PC_W-1:0] seq_pc;
        string           tag;
    } exp_t;

    exp_t exp_q[$];
    exp_t last_exp;
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 1'b0;

    function automatic logic ref_pass(input logic [3:0] c, input logic [3:0] f);
        logic n, z, cy, v;
        n = f[3]; z = f[2]; cy = f[1]; v = f[0];
        case (c)
            4'h0: return z;
            4'h1: return !z;
            4'h2: return cy;
            4'h3: return !cy;
            4'h4: return n;
            4'h5: return !n;
            4'h6: return v;
            4'h7: return !v;
            4'h8: return cy && !z;
            4'h9: return !cy || z;
            4'hA: return n == v;
            4'hB: return n != v;
            4'hC: return !z && (n == v);
            4'hD: return z || (n != v);
            default: return 1'b1;
        endcase
    endfunction

    function automatic string code_tag(input logic [3:0] c);
        if (c < 4'h8) return "R2";
        if (c < 4'hA) return "R3";
        if (c < 4'hE) return "R4";
        return "R5";
    endfunction

    task automatic check(input string tag, input bit ok, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // driver: applies one request and pushes its expected result
    task automatic drive(input bit half, input logic [3:0] f,
                         input logic [INSN_W-1:0] insn, input logic [PC_W-1:0] pc,
                         input string tag_override);
        exp_t e;
        logic [3:0] c;
        bit tested;
        @(negedge clk);
        valid_i     = 1'b1;
        half_mode_i = half;
        flags_i     = f;
        insn_i      = insn;
        pc_i        = pc;
        if (half) begin
            tested = (insn[15:12] == 4'hD);
            c      = insn[11:8];
        end else begin
            tested = 1'b1;
            c      = insn[31:28];
        end
        e.pass    = tested ? ref_pass(c, f) : 1'b1;
        e.is_cond = tested && (c < 4'hE);
        e.seq_pc  = pc + (half ? PC_W'(2) : PC_W'(4));
        e.tag     = (tag_override != "") ? tag_override : code_tag(c);
        exp_q.push_back(e);
    endtask

    // monitor: pops and compares each result
    always @(negedge clk) begin
        if (rst_n && res_valid_o) begin
            if (exp_q.size() == 0) begin
                check("R9", 1'b0, "unexpected result", 64'(res_valid_o), 64'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                last_exp = e;
                n_checks++;
                if (pass_o !== e.pass || is_cond_o !== e.is_cond || seq_pc_o !== e.seq_pc) begin
                    n_fail++;
                    $display("FAIL %s pass/is_cond/seq_pc actual=%0b/%0b/%0h expected=%0b/%0b/%0h",
                             e.tag, pass_o, is_cond_o, seq_pc_o, e.pass, e.is_cond, e.seq_pc);
                end
            end
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", res_valid_o === 1'b0, "res_valid_o in reset", 64'(res_valid_o), 64'd0);
        check("R1", pass_o === 1'b0 && is_cond_o === 1'b0, "pass/is_cond in reset",
              64'({pass_o, is_cond_o}), 64'd0);
        check("R1", seq_pc_o === '0, "seq_pc_o in reset", 64'(seq_pc_o), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", res_valid_o === 1'b0 && pass_o === 1'b0, "idle after reset",
              64'({res_valid_o, pass_o}), 64'd0);

        // R2..R5: 32-bit mode, every code against every flag combination
        for (int c = 0; c < 16; c++) begin
            for (int f = 0; f < 16; f++) begin
                logic [INSN_W-1:0] w;
                w = {4'(c), 28'($urandom)};
                drive(1'b0, 4'(f), w, PC_W'($urandom) & ~PC_W'(3), "");
            end
        end

        // R6: 16-bit conditional branches, every code against every flag set
        for (int c = 0; c < 16; c++) begin
            for (int f = 0; f < 16; f++) begin
                logic [INSN_W-1:0] w;
                w = {16'($urandom), 4'hD, 4'(c), 8'($urandom)};
                drive(1'b1, 4'(f), w, PC_W'($urandom) & ~PC_W'(1), "R6");
            end
        end

        // R7: 16-bit opcodes that are not conditional branches
        for (int s = 0; s < 16; s++) begin
            if (s == 13) continue;
            for (int k = 0; k < 4; k++) begin
                logic [INSN_W-1:0] w;
                w = {16'($urandom), 4'(s), 12'($urandom)};
                drive(1'b1, 4'(k * 5), w, PC_W'($urandom), "R7");
            end
        end

        // R7: upper half ignored in 16-bit mode, including a full-width always code
        drive(1'b1, 4'b0000, 32'hE000_D000, 32'h100, "R7");    // EQ with Z=0 -> fail
        drive(1'b1, 4'b0100, 32'h0000_D100, 32'h100, "R7");    // NE with Z=1 -> fail

        // R8: wrap-around of the sequential address
        drive(1'b0, 4'b0000, 32'h0000_0000, 32'hFFFF_FFFC, "R8");
        drive(1'b1, 4'b0000, 32'h0000_D000, 32'hFFFF_FFFF, "R8");

        // R9: idle cycles with changed inputs leave the outputs untouched
        @(negedge clk);
        valid_i     = 1'b0;
        half_mode_i = 1'b0;
        flags_i     = 4'b1111;
        insn_i      = 32'h1234_5678;
        pc_i        = 32'hABCD_0000;
        repeat (3) @(negedge clk);
        check("R9", res_valid_o === 1'b0, "res_valid_o when idle", 64'(res_valid_o), 64'd0);
        check("R9", pass_o === last_exp.pass && is_cond_o === last_exp.is_cond,
              "pass/is_cond held when idle", 64'({pass_o, is_cond_o}),
              64'({last_exp.pass, last_exp.is_cond}));
        check("R9", seq_pc_o === last_exp.seq_pc, "seq_pc held when idle",
              64'(seq_pc_o), 64'(last_exp.seq_pc));
        check("R9", exp_q.size() == 0, "results outstanding", 64'(exp_q.size()), 64'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule